// File: doc/BRIEF.md
# Flash Command Interface and Write Sequencer

This block models the command front end of a NOR-style flash memory on a 16-bit bus. Software writes command bytes (the low eight bits of the write data) to any address. One-cycle commands select what a read returns: array contents, identifier words, or the status register. They also clear the error flags, suspend a running operation or resume it. Two-cycle commands start a word write or a block erase. The second cycle carries the target address and either the data or the confirm byte.

Word writes and block erases are timed by parameterised busy counters. A word write ANDs the new data into the stored word, so it can only clear bits. A block erase sets every word of the addressed block to FFFFh. Both run against a small internal register-file array. A running erase can be suspended, a word write can then be run and suspended in turn, and each is resumed in order. At the second cycle of each sequence the block checks the supply-ok, reset-pin and write-protect inputs. A lock aborts the operation and sets a sticky status flag. A ready/busy pin pair reports the operation state. The bus has no back-pressure: a write or read strobe is taken in the cycle it is high, and every read returns exactly one cycle later with a valid flag.

NUM_BLOCKS and BLOCK_WORDS must be powers of two, with at least two blocks. The boot blocks are blocks 0 to NUM_BOOT-1. Reads and writes must not be strobed in the same cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read path selects the array, every word holds FFFFh, the block is ready (rb_level=1, rb_drive=1), and the status register reads 0080h.
- R2: Command FFh selects array reads, 90h selects identifier reads and 70h selects status reads. Identifier address 0 returns 00B0h, address 1 returns DEV_CODE, and any other address returns 0000h. A read strobe in cycle N gives rd_valid and rd_data in cycle N+1, using the mode and state that held before the edge.
- R3: Word write is 40h or 10h followed by a data cycle at the target address. The block is busy for exactly WRITE_CYCLES cycles, after which the stored word equals the old word AND the new data. Starting the operation switches reads to status.
- R4: Block erase is 20h followed by D0h, both addressed in the same block. The block is busy for exactly ERASE_CYCLES cycles, after which every word of that block reads FFFFh.
- R5: If the second erase cycle is not D0h, or is addressed in another block, no erase starts and status bits 5 and 4 are both set.
- R6: At the second cycle, vpp_ok=0 aborts the operation with status bit 3 set. Otherwise the target is locked when rp_n=0, unlocked when rp_hv=1, and, when rp_n=1 and rp_hv=0, locked only for a boot block with wp_n=0. A lock aborts the operation with status bit 1 set. An aborted operation leaves the array unchanged and the block ready.
- R7: Status bits 5, 4, 3 and 1 stay set until command 50h clears all four. Command 50h does not change the read mode.
- R8: The status byte is, from bit 7 down: ready, erase suspended, erase error, write error, supply error, write suspended, lock error, and 0. The upper byte reads 00h.
- R9: B0h while busy suspends the running operation. It stops counting, the block reports ready, and the suspend bit is set. D0h resumes the most recent suspension, which then finishes its remaining cycles. If the operation completes on the same edge as the B0h, the suspend has no effect.
- R10: While an erase is suspended, a word write (to any block) and array reads are accepted, and that word write can itself be suspended. The first D0h resumes the write, and the erase resumes only on a D0h after the write has finished.
- R11: rb_drive=1 with rb_level=0 while busy. rb_drive=0 while not busy with any operation suspended. rb_drive=1 with rb_level=1 otherwise.
- R12: While busy, every write other than B0h is ignored; in particular it does not change the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Word address (block index in the upper bits) |
| bus_wdata | input | 16 | Write data; commands in bits 7:0 |
| bus_we | input | 1 | Write strobe, one transfer per cycle high |
| bus_re | input | 1 | Read strobe, one transfer per cycle high |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read strobe |
| vpp_ok | input | 1 | Program supply within range |
| rp_n | input | 1 | Reset pin at normal high level |
| rp_hv | input | 1 | Reset pin at the high-voltage unlock level |
| wp_n | input | 1 | Write protect, low protects boot blocks |
| rb_level | output | 1 | Ready/busy level (1 ready, 0 busy) |
| rb_drive | output | 1 | Ready/busy driver enable (0 = released) |

## Verification
A read strobe returns its data on the next cycle, and a command written in one cycle changes the mode, the status and the ready/busy pins from the following cycle. An operation started at the edge of its second bus cycle keeps the block busy for exactly WRITE_CYCLES or ERASE_CYCLES edges, and suspended cycles are not counted. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge, and read data and the ready/busy pins are compared with it at every falling edge, so each result is checked in the one cycle it is due. Directed reads confirm array contents, identifier codes and status values after each scenario.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_mode_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_ERASE, PEND_WRITE} pend_e;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR_STAT   = 8'h50;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_WRITE_A    = 8'h40;
  localparam logic [7:0] OP_WRITE_B    = 8'h10;
  localparam logic [7:0] OP_SUSPEND    = 8'hB0;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;

  localparam logic [15:0] MFR_CODE = 16'h00B0;
endpackage

// File: rtl/fci_lock_check.sv
module fci_lock_check #(
  parameter int BLK_W    = 3,
  parameter int NUM_BOOT = 2
) (
  input  logic             vpp_ok,
  input  logic             rp_n,
  input  logic             rp_hv,
  input  logic             wp_n,
  input  logic [BLK_W-1:0] blk,
  output logic             vpp_fail,
  output logic             lock_fail
);
  localparam logic [BLK_W:0] BOOT_LIM = (BLK_W+1)'(NUM_BOOT);

  logic is_boot;
  assign is_boot  = ({1'b0, blk} < BOOT_LIM);
  assign vpp_fail = !vpp_ok;

  always_comb begin
    if (!rp_n)      lock_fail = 1'b1;
    else if (rp_hv) lock_fail = 1'b0;
    else            lock_fail = !wp_n && is_boot;
  end
endmodule

// File: rtl/fci_busy_timer.sv
module fci_busy_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = run && !load && (cnt_q == CNT_W'(1));

  // R3 / R4: every running cycle consumes exactly one count
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9: a paused operation keeps its remaining count
  p_hold_paused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_WORDS = 4,
  localparam int WORDS = NUM_BLOCKS * BLOCK_WORDS,
  localparam int AW    = $clog2(WORDS),
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             er_en,
  input  logic [BLK_W-1:0] er_blk,
  input  logic [AW-1:0]    rd_addr,
  output logic [15:0]      rd_word
);
  logic [15:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (er_en && er_blk == BLK_W'(i / BLOCK_WORDS))
          mem_q[i] <= '1;
        else if (wr_en && wr_addr == AW'(i))
          mem_q[i] <= mem_q[i] & wr_data;
      end
    end
  end

  assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int NUM_BLOCKS   = 8,
  parameter int BLOCK_WORDS  = 4,
  parameter int NUM_BOOT     = 2,
  parameter int WRITE_CYCLES = 6,
  parameter int ERASE_CYCLES = 20,
  parameter logic [15:0] DEV_CODE = 16'h005A,
  localparam int WORDS = NUM_BLOCKS * BLOCK_WORDS,
  localparam int AW    = $clog2(WORDS),
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int OFS_W = $clog2(BLOCK_WORDS),
  localparam int MAXC  = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [15:0]   rd_data,
  output logic          rd_valid,
  input  logic          vpp_ok,
  input  logic          rp_n,
  input  logic          rp_hv,
  input  logic          wp_n,
  output logic          rb_level,
  output logic          rb_drive
);
  // ---------------- state ----------------
  rd_mode_e         mode_q, mode_d;
  pend_e            pend_q, pend_d;
  logic [BLK_W-1:0] pend_blk_q;
  logic             w_act_q, w_susp_q;
  logic [AW-1:0]    w_addr_q;
  logic [15:0]      w_data_q;
  logic             e_act_q, e_susp_q;
  logic [BLK_W-1:0] e_blk_q;
  logic             err_e_q, err_w_q, err_vpp_q, err_prot_q;

  // ---------------- decode outputs ----------------
  logic       start_w, start_e, set_e, set_w, set_vpp, set_prot, clr_err;
  logic       susp_w_req, susp_e_req, res_w, res_e;
  logic       w_run, e_run, busy, done_w, done_e;
  logic       vpp_fail, lock_fail;
  logic [7:0] op;
  logic [BLK_W-1:0] addr_blk;
  logic [15:0] stat_word, arr_word, id_word;

  assign op       = bus_wdata[7:0];
  assign addr_blk = bus_addr[AW-1:OFS_W];
  assign w_run    = w_act_q && !w_susp_q;
  assign e_run    = e_act_q && !e_susp_q && !w_act_q;
  assign busy     = w_run || e_run;

  fci_lock_check #(.BLK_W(BLK_W), .NUM_BOOT(NUM_BOOT)) u_lock (
    .vpp_ok(vpp_ok), .rp_n(rp_n), .rp_hv(rp_hv), .wp_n(wp_n),
    .blk(addr_blk), .vpp_fail(vpp_fail), .lock_fail(lock_fail)
  );

  fci_busy_timer #(.CNT_W(CNT_W)) u_wtimer (
    .clk(clk), .rst_n(rst_n), .load(start_w),
    .load_val(CNT_W'(WRITE_CYCLES)), .run(w_run), .done(done_w)
  );

  fci_busy_timer #(.CNT_W(CNT_W)) u_etimer (
    .clk(clk), .rst_n(rst_n), .load(start_e),
    .load_val(CNT_W'(ERASE_CYCLES)), .run(e_run), .done(done_e)
  );

  fci_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(done_w), .wr_addr(w_addr_q), .wr_data(w_data_q),
    .er_en(done_e), .er_blk(e_blk_q),
    .rd_addr(bus_addr), .rd_word(arr_word)
  );

  // ---------------- command decode ----------------
  always_comb begin
    mode_d     = mode_q;
    pend_d     = pend_q;
    start_w    = 1'b0;
    start_e    = 1'b0;
    set_e      = 1'b0;
    set_w      = 1'b0;
    set_vpp    = 1'b0;
    set_prot   = 1'b0;
    clr_err    = 1'b0;
    susp_w_req = 1'b0;
    susp_e_req = 1'b0;
    res_w      = 1'b0;
    res_e      = 1'b0;
    if (bus_we) begin
      if (busy) begin
        if (op == OP_SUSPEND) begin
          if (w_run) susp_w_req = 1'b1;
          else       susp_e_req = 1'b1;
        end
      end else if (pend_q != PEND_NONE) begin
        pend_d = PEND_NONE;
        mode_d = RD_STATUS;
        if (pend_q == PEND_ERASE && (op != OP_CONFIRM || addr_blk != pend_blk_q)) begin
          set_e = 1'b1;
          set_w = 1'b1;
        end else if (vpp_fail) begin
          set_vpp = 1'b1;
        end else if (lock_fail) begin
          set_prot = 1'b1;
        end else if (pend_q == PEND_ERASE) begin
          start_e = 1'b1;
        end else begin
          start_w = 1'b1;
        end
      end else begin
        unique case (op)
          OP_READ_ARRAY: mode_d = RD_ARRAY;
          OP_READ_ID:    mode_d = RD_IDENT;
          OP_READ_STAT:  mode_d = RD_STATUS;
          OP_CLR_STAT:   clr_err = 1'b1;
          OP_ERASE:      if (!w_act_q && !e_act_q) pend_d = PEND_ERASE;
          OP_WRITE_A,
          OP_WRITE_B:    if (!w_act_q) pend_d = PEND_WRITE;
          OP_CONFIRM: begin
            if (w_susp_q) begin
              res_w  = 1'b1;
              mode_d = RD_STATUS;
            end else if (e_susp_q && !w_act_q) begin
              res_e  = 1'b1;
              mode_d = RD_STATUS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= RD_ARRAY;
      pend_q     <= PEND_NONE;
      pend_blk_q <= '0;
      w_act_q    <= 1'b0;
      w_susp_q   <= 1'b0;
      w_addr_q   <= '0;
      w_data_q   <= '0;
      e_act_q    <= 1'b0;
      e_susp_q   <= 1'b0;
      e_blk_q    <= '0;
      err_e_q    <= 1'b0;
      err_w_q    <= 1'b0;
      err_vpp_q  <= 1'b0;
      err_prot_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      if (bus_we && !busy && pend_q == PEND_NONE && op == OP_ERASE) pend_blk_q <= addr_blk;

      if (start_w) begin
        w_act_q  <= 1'b1;
        w_susp_q <= 1'b0;
        w_addr_q <= bus_addr;
        w_data_q <= bus_wdata;
      end else if (done_w) begin
        w_act_q <= 1'b0;
      end
      if (susp_w_req && !done_w) w_susp_q <= 1'b1;
      if (res_w)                 w_susp_q <= 1'b0;

      if (start_e) begin
        e_act_q  <= 1'b1;
        e_susp_q <= 1'b0;
        e_blk_q  <= addr_blk;
      end else if (done_e) begin
        e_act_q <= 1'b0;
      end
      if (susp_e_req && !done_e) e_susp_q <= 1'b1;
      if (res_e)                 e_susp_q <= 1'b0;

      if (clr_err) begin
        err_e_q    <= 1'b0;
        err_w_q    <= 1'b0;
        err_vpp_q  <= 1'b0;
        err_prot_q <= 1'b0;
      end else begin
        err_e_q    <= err_e_q    | set_e;
        err_w_q    <= err_w_q    | set_w;
        err_vpp_q  <= err_vpp_q  | set_vpp;
        err_prot_q <= err_prot_q | set_prot;
      end
    end
  end

  // ---------------- read path ----------------
  assign stat_word = {8'h00, !busy, e_susp_q, err_e_q, err_w_q,
                      err_vpp_q, w_susp_q, err_prot_q, 1'b0};

  always_comb begin
    if (bus_addr == AW'(0))      id_word = MFR_CODE;
    else if (bus_addr == AW'(1)) id_word = DEV_CODE;
    else                         id_word = 16'h0000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_re;
      if (bus_re) begin
        unique case (mode_q)
          RD_ARRAY: rd_data <= arr_word;
          RD_IDENT: rd_data <= id_word;
          default:  rd_data <= stat_word;
        endcase
      end
    end
  end

  assign rb_level = !busy;
  assign rb_drive = busy || !(w_susp_q || e_susp_q);

  // ---------------- assertions ----------------
  // R5: a bad second erase cycle raises both error flags
  p_improper_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !busy && pend_q == PEND_ERASE && op != OP_CONFIRM) |=> (err_e_q && err_w_q));

  // R6: a supply failure at the data cycle leaves the block ready
  p_vpp_abort_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !busy && pend_q == PEND_WRITE && !vpp_ok) |=> (rb_level && err_vpp_q));

  // R7: the lock flag drops only after a clear-status command
  p_sticky_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_prot_q) |-> $past(bus_we && bus_wdata[7:0] == OP_CLR_STAT));

  // R9: erase suspension only follows a suspend command
  p_erase_susp_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_susp_q) |-> $past(bus_we && bus_wdata[7:0] == OP_SUSPEND));

  // R12: a read-array command while busy leaves reads on status
  p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && busy && op == OP_READ_ARRAY && mode_q == RD_STATUS) |=> (mode_q == RD_STATUS));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int NB = 8, BWD = 4, WC = 6, EC = 20, WORDS = NB * BWD, AW = 5;
  localparam logic [15:0] DEV = 16'h005A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0]   rd_data;
  logic          rd_valid;
  logic          vpp_ok = 1'b1, rp_n = 1'b1, rp_hv = 1'b0, wp_n = 1'b1;
  logic          rb_level, rb_drive;

  flash_cmd_ctrl #(.NUM_BLOCKS(NB), .BLOCK_WORDS(BWD), .NUM_BOOT(2),
                   .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .DEV_CODE(DEV)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .rd_data(rd_data), .rd_valid(rd_valid),
    .vpp_ok(vpp_ok), .rp_n(rp_n), .rp_hv(rp_hv), .wp_n(wp_n),
    .rb_level(rb_level), .rb_drive(rb_drive)
  );

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_mode, m_pend, m_pblk;      // mode 0 array, 1 id, 2 status; pend 0 none, 1 erase, 2 write
  bit          m_wact, m_wsusp, m_eact, m_esusp;
  int          m_wrem, m_erem, m_waddr, m_eblk;
  logic [15:0] m_wdata;
  bit          m_err_e, m_err_w, m_err_v, m_err_p;
  logic [15:0] m_mem [WORDS];
  bit          m_rdv;
  logic [15:0] m_rdd;

  function automatic bit m_busy();
    return (m_wact && !m_wsusp) || (m_eact && !m_esusp && !m_wact);
  endfunction

  function automatic logic [15:0] m_status();
    return {8'h00, !m_busy(), m_esusp, m_err_e, m_err_w, m_err_v, m_wsusp, m_err_p, 1'b0};
  endfunction

  function automatic bit m_locked(input int blk);
    if (!rp_n) return 1'b1;
    if (rp_hv) return 1'b0;
    return !wp_n && blk < 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_pblk = 0;
      m_wact = 0; m_wsusp = 0; m_eact = 0; m_esusp = 0;
      m_wrem = 0; m_erem = 0; m_waddr = 0; m_eblk = 0; m_wdata = 0;
      m_err_e = 0; m_err_w = 0; m_err_v = 0; m_err_p = 0;
      for (int i = 0; i < WORDS; i++) m_mem[i] = 16'hFFFF;
      m_rdv = 0; m_rdd = 0;
    end else begin
      bit busy_pre, wrun, erun;
      logic [15:0] stat_pre;
      logic [7:0] op;
      int blk;
      busy_pre = m_busy();
      stat_pre = m_status();
      m_rdv = bus_re;
      if (bus_re) begin
        if (m_mode == 0) m_rdd = m_mem[bus_addr];
        else if (m_mode == 1) m_rdd = (bus_addr == 0) ? 16'h00B0 : (bus_addr == 1) ? DEV : 16'h0000;
        else m_rdd = stat_pre;
      end
      wrun = m_wact && !m_wsusp;
      erun = m_eact && !m_esusp && !m_wact;
      if (wrun) begin
        m_wrem--;
        if (m_wrem == 0) begin m_mem[m_waddr] = m_mem[m_waddr] & m_wdata; m_wact = 0; end
      end else if (erun) begin
        m_erem--;
        if (m_erem == 0) begin
          for (int i = 0; i < BWD; i++) m_mem[m_eblk * BWD + i] = 16'hFFFF;
          m_eact = 0;
        end
      end
      if (bus_we) begin
        op  = bus_wdata[7:0];
        blk = int'(bus_addr) / BWD;
        if (busy_pre) begin
          if (op == 8'hB0) begin
            if (wrun) begin if (m_wact) m_wsusp = 1; end
            else if (m_eact) m_esusp = 1;
          end
        end else if (m_pend != 0) begin
          m_mode = 2;
          if (m_pend == 1 && (op != 8'hD0 || blk != m_pblk)) begin
            m_err_e = 1; m_err_w = 1;
          end else if (!vpp_ok) m_err_v = 1;
          else if (m_locked(blk)) m_err_p = 1;
          else if (m_pend == 1) begin
            m_eact = 1; m_esusp = 0; m_erem = EC; m_eblk = blk;
          end else begin
            m_wact = 1; m_wsusp = 0; m_wrem = WC; m_waddr = int'(bus_addr); m_wdata = bus_wdata;
          end
          m_pend = 0;
        end else begin
          case (op)
            8'hFF: m_mode = 0;
            8'h90: m_mode = 1;
            8'h70: m_mode = 2;
            8'h50: begin m_err_e = 0; m_err_w = 0; m_err_v = 0; m_err_p = 0; end
            8'h20: if (!m_wact && !m_eact) begin m_pend = 1; m_pblk = blk; end
            8'h40, 8'h10: if (!m_wact) m_pend = 2;
            8'hD0: begin
              if (m_wsusp) begin m_wsusp = 0; m_mode = 2; end
              else if (m_esusp && !m_wact) begin m_esusp = 0; m_mode = 2; end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // per-clock comparison against the model (R2 read timing, R11 pin)
  always @(negedge clk) begin
    if (rst_n) begin
      check(rd_valid == m_rdv, "R2 rd_valid timing", {15'd0, rd_valid}, {15'd0, m_rdv});
      if (m_rdv) check(rd_data == m_rdd, "R2 rd_data vs model", rd_data, m_rdd);
      check(rb_level == !m_busy(), "R11 rb_level vs model", {15'd0, rb_level}, {15'd0, !m_busy()});
      check(rb_drive == (m_busy() || !(m_wsusp || m_esusp)), "R11 rb_drive vs model",
            {15'd0, rb_drive}, {15'd0, m_busy() || !(m_wsusp || m_esusp)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int addr, input logic [15:0] data);
    bus_addr = AW'(addr); bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input int addr, input logic [15:0] exp, input string tag);
    bus_addr = AW'(addr); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    check(rb_level && rb_drive, "R1 ready after reset", {14'd0, rb_level, rb_drive}, 16'h0003);
    rd_expect(5, 16'hFFFF, "R1 array erased at reset");
    wr(0, 16'h0070);
    rd_expect(0, 16'h0080, "R1 R8 status after reset");

    // R2: identifier reads
    wr(0, 16'h0090);
    rd_expect(0, 16'h00B0, "R2 manufacturer code");
    rd_expect(1, DEV, "R2 device code");
    rd_expect(2, 16'h0000, "R2 other identifier address");

    // R3: word write, AND semantics, busy length
    wr(9, 16'h0040);
    wr(9, 16'h1234);
    check(!rb_level, "R3 busy after data cycle", {15'd0, rb_level}, 16'h0000);
    rd_expect(9, 16'h0000, "R3 status read while busy");
    idle(WC);
    rd_expect(9, 16'h0080, "R3 ready after write");
    wr(0, 16'h00FF);
    rd_expect(9, 16'h1234, "R3 written word");
    wr(9, 16'h0010);
    wr(9, 16'h0F0F);
    idle(WC + 1);
    wr(0, 16'h00FF);
    rd_expect(9, 16'h0204, "R3 write only clears bits");

    // R4: block erase
    wr(8, 16'h0020);
    wr(10, 16'h00D0);
    idle(EC + 2);
    wr(0, 16'h00FF);
    rd_expect(9, 16'hFFFF, "R4 block erased");

    // R5 / R7: improper sequence and sticky errors
    wr(8, 16'h0020);
    wr(8, 16'h00FF);
    rd_expect(8, 16'h00B0, "R5 improper erase flags");
    wr(0, 16'h0070);
    rd_expect(0, 16'h00B0, "R7 errors sticky");
    wr(0, 16'h0050);
    rd_expect(0, 16'h0080, "R7 clear status");
    wr(8, 16'h0020);
    wr(12, 16'h00D0);
    rd_expect(8, 16'h00B0, "R5 confirm in other block");
    wr(0, 16'h0050);

    // R6: protection rules
    wp_n = 1'b0;
    wr(1, 16'h0040);
    wr(1, 16'h0000);
    rd_expect(1, 16'h0082, "R6 boot block locked");
    vpp_ok = 1'b0;
    wr(12, 16'h0040);
    wr(12, 16'h0000);
    rd_expect(12, 16'h008A, "R6 supply low abort");
    wr(0, 16'h0050);
    vpp_ok = 1'b1;
    wr(0, 16'h00FF);
    rd_expect(1, 16'hFFFF, "R6 aborted write left array");
    rd_expect(12, 16'hFFFF, "R6 aborted write left array");
    rp_hv = 1'b1;
    wr(1, 16'h0040);
    wr(1, 16'h00FF);
    idle(WC + 1);
    wr(0, 16'h00FF);
    rd_expect(1, 16'h00FF, "R6 high-voltage unlock");
    rp_hv = 1'b0; rp_n = 1'b0; wp_n = 1'b1;
    wr(16, 16'h0040);
    wr(16, 16'h0000);
    rd_expect(16, 16'h0082, "R6 reset pin low locks all");
    wr(0, 16'h0050);
    rp_n = 1'b1;

    // R12, R9, R10, R11: busy filtering, suspend, nested write
    wr(21, 16'h0040);
    wr(21, 16'h0000);
    idle(WC + 1);
    wr(20, 16'h0020);
    wr(22, 16'h00D0);
    wr(0, 16'h00FF);
    rd_expect(0, 16'h0000, "R12 read-array ignored while busy");
    wr(0, 16'h00B0);
    check(rb_level && !rb_drive, "R11 released while suspended", {14'd0, rb_level, rb_drive}, 16'h0002);
    rd_expect(0, 16'h00C0, "R9 erase suspended status");
    idle(30);
    rd_expect(0, 16'h00C0, "R9 erase stays suspended");
    wr(16, 16'h0040);
    wr(16, 16'h00F0);
    check(!rb_level && rb_drive, "R10 nested write busy", {14'd0, rb_level, rb_drive}, 16'h0001);
    wr(0, 16'h00B0);
    rd_expect(0, 16'h00C4, "R10 both suspended");
    wr(0, 16'h00FF);
    rd_expect(16, 16'hFFFF, "R10 array read during suspend");
    rd_expect(21, 16'h0000, "R9 erase not applied yet");
    wr(0, 16'h00D0);
    idle(WC + 1);
    rd_expect(0, 16'h00C0, "R10 write resumed first");
    wr(0, 16'h00FF);
    rd_expect(16, 16'h00F0, "R10 nested write result");
    wr(0, 16'h00D0);
    idle(EC + 2);
    rd_expect(0, 16'h0080, "R9 erase resumed and done");
    wr(0, 16'h00FF);
    rd_expect(21, 16'hFFFF, "R4 R9 erase completed after resume");

    idle(2);
    finish_run();
  end
endmodule